// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block times one successive-approximation conversion from start request to finished 12-bit code. It runs entirely on the master clock and derives an ADC clock as a one-cycle enable that fires once every 2, 4, 8 or 16 master cycles. A start request can come from a software pulse, a timer overflow pulse, or a rising edge on an external convert pin. The external pin passes through a synchronizer first.

Requests are only taken while the block is idle. Each accepted request is aligned to the next ADC clock. It then runs a fixed frame of one synchronization clock, a selectable acquisition window of 1 to 4 ADC clocks with the track output high, and 15 conversion clocks.

During the first 12 conversion clocks the block presents a trial code to an external comparator and takes one decision per clock, starting with the most significant bit. At the end of the frame it updates the result, pulses done and drops busy. In continuous mode a new frame begins as soon as the previous one ends.

Top module: `adc_seq_top`

## Requirements
- R1: `div_sel` values 0, 1, 2 and 3 give an ADC clock of 2, 4, 8 and 16 master cycles respectively (value 1 is divide-by-4).
- R2: The divide ratio is sampled only while idle; a change of `div_sel` during a conversion does not alter that conversion's timing.
- R3: `track_o` is high for exactly (acq_sel+1) ADC clocks per conversion, i.e. (acq_sel+1) times the divide ratio in master cycles.
- R4: In single mode `busy_o` stays high for exactly (1 + (acq_sel+1) + 15) ADC clocks per conversion, as one unbroken span.
- R5: A start request of any kind that arrives while busy is dropped; it produces no further conversion.
- R6: `step_o` pulses exactly 12 times per conversion, once per decision, MSB first. `dac_code_o` shows the trial code, and `result_o` equals the value found by the comparator's decisions. `result_o` changes only at the end of a conversion.
- R7: `done_o` is a one-master-cycle pulse in the cycle `result_o` updates; in single mode `busy_o` is low in that same cycle.
- R8: With `cont_en` high, the next conversion starts at the end of the current one. `busy_o` stays high through `done_o`, and done pulses are spaced by one full frame.
- R9: The external pin starts a conversion only on a low-to-high transition; holding it high starts nothing more. `sw_start` and `timer_ovf` start a conversion on a one-cycle pulse.
- R10: After reset `busy_o`, `track_o`, `step_o` and `done_o` are low, and `result_o` and `dac_code_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | ADC clock divide select (2/4/8/16) |
| acq_sel | input | 2 | Acquisition length select (1..4 ADC clocks) |
| cont_en | input | 1 | Continuous conversion enable |
| sw_start | input | 1 | Software start pulse |
| timer_ovf | input | 1 | Timer overflow start pulse |
| ext_cnv | input | 1 | External convert pin, asynchronous, rising edge active |
| cmp_i | input | 1 | Comparator decision: 1 when input is at or above `dac_code_o` |
| dac_code_o | output | 12 | Current trial code for the comparator |
| step_o | output | 1 | Marks the cycle in which `cmp_i` is taken |
| track_o | output | 1 | High while tracking, low while holding |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse on result update |
| result_o | output | 12 | Last completed conversion code |

## Verification
The assertions assume that `cmp_i` is settled in any cycle where `step_o` is high, and that `div_sel` and `acq_sel` may change at any time. The comparator model in the bench is combinational on `dac_code_o`, so its answer is always settled in time.

The bench drives start pulses and configuration changes on the falling clock edge. It keeps the analog input constant across each conversion. It deliberately changes `div_sel` and raises all three start sources mid-conversion, which exercises the idle-only sampling and the dropping of start requests.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SEL_W     = 2;
    localparam int CNT_W     = 5;   // holds the largest ratio (16)
    localparam int PH_W      = 4;   // counts ADC clocks within a phase
    localparam int RES_BITS  = 12;
    localparam int CONV_LEN  = 15;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SYNC,
        PH_ACQ,
        PH_CONV
    } phase_e;

    // Control bundle from the phase controller to the SAR register
    typedef struct packed {
        logic            load;    // start of conversion phase: seed trial code
        logic            step;    // take one comparator decision
        logic [PH_W-1:0] idx;     // decision number, 0 = MSB
        logic            finish;  // end of frame: publish result
    } sar_ctl_t;

    // Master cycles per ADC clock for a divide select value
    function automatic logic [CNT_W-1:0] ratio_of(input logic [SEL_W-1:0] s);
        return CNT_W'(2) << s;
    endfunction

    // ADC clocks of acquisition for an acquisition select value
    function automatic logic [PH_W-1:0] acq_of(input logic [SEL_W-1:0] s);
        return PH_W'(s) + PH_W'(1);
    endfunction

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;

    // A ratio change can only be picked up while the sequencer is idle
    assign tick = (cnt_q >= (ratio_of(sel_q) - CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else begin
            if (idle) sel_q <= sel;
            if (tick) cnt_q <= '0;
            else      cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(sel_q)); // R2

endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sw_start,
    input  logic timer_ovf,
    input  logic ext_cnv,
    input  logic idle,
    input  logic accept,
    output logic pending
);

    localparam int SYNC_STAGES = 3;

    logic [SYNC_STAGES-1:0] ext_sr;
    logic                   ext_rise;
    logic                   any_req;
    logic                   pend_q;

    // Two flops for metastability, a third to find the rising edge
    always_ff @(posedge clk) begin
        if (rst) ext_sr <= '0;
        else     ext_sr <= {ext_sr[SYNC_STAGES-2:0], ext_cnv};
    end

    assign ext_rise = ext_sr[SYNC_STAGES-2] & ~ext_sr[SYNC_STAGES-1];
    assign any_req  = sw_start | timer_ovf | ext_rise;

    // Requests are only remembered while idle; during a conversion they are lost
    always_ff @(posedge clk) begin
        if (rst)                    pend_q <= 1'b0;
        else if (accept)            pend_q <= 1'b0;
        else if (idle && any_req)   pend_q <= 1'b1;
    end

    assign pending = pend_q;

    AST_PEND_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(idle)); // R5

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = RES_BITS,
    parameter int CONV_CLKS = CONV_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             pending,
    input  logic [SEL_W-1:0] acq_sel,
    input  logic             cont_en,
    output logic             idle,
    output logic             accept,
    output logic             track,
    output logic             done,
    output sar_ctl_t         sar_ctl
);

    phase_e          state_q;
    logic [PH_W-1:0] cnt_q;
    logic [PH_W-1:0] acq_q;
    logic            done_q;
    logic            last_acq;
    logic            last_conv;
    logic            finish;

    assign idle      = (state_q == PH_IDLE);
    assign track     = (state_q == PH_ACQ);
    assign last_acq  = (cnt_q == acq_q - PH_W'(1));
    assign last_conv = (cnt_q == PH_W'(CONV_CLKS - 1));
    assign accept    = tick && idle && pending;
    assign finish    = tick && (state_q == PH_CONV) && last_conv;

    always_comb begin
        sar_ctl.load   = tick && (state_q == PH_ACQ) && last_acq;
        sar_ctl.step   = tick && (state_q == PH_CONV) && (cnt_q < PH_W'(RES_W));
        sar_ctl.idx    = cnt_q;
        sar_ctl.finish = finish;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            acq_q   <= PH_W'(1);
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (tick) begin
                case (state_q)
                    PH_IDLE: begin
                        if (pending) begin
                            state_q <= PH_SYNC;
                            acq_q   <= acq_of(acq_sel);
                        end
                    end
                    PH_SYNC: begin
                        state_q <= PH_ACQ;
                        cnt_q   <= '0;
                    end
                    PH_ACQ: begin
                        if (last_acq) begin
                            state_q <= PH_CONV;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + PH_W'(1);
                        end
                    end
                    PH_CONV: begin
                        cnt_q <= last_conv ? '0 : cnt_q + PH_W'(1);
                        if (last_conv) begin
                            if (cont_en) begin
                                state_q <= PH_SYNC;
                                acq_q   <= acq_of(acq_sel);
                            end else begin
                                state_q <= PH_IDLE;
                            end
                        end
                    end
                    default: state_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign done = done_q;

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(idle) |-> done_q); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R7
    AST_CONV_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_CONV && $past(state_q) != PH_CONV) |-> $past(state_q) == PH_ACQ); // R4
    AST_ACQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (track && $past(track)) |-> $stable(acq_q)); // R3

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar
    import adc_seq_pkg::*;
#(
    parameter int RES_W = RES_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  sar_ctl_t         ctl,
    input  logic             cmp,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result
);

    logic [RES_W-1:0] trial_q;
    logic [RES_W-1:0] trial_nxt;
    logic [RES_W-1:0] result_q;

    // Decision idx settles bit (RES_W-1-idx) and raises the bit below it
    always_comb begin
        int b;
        b = RES_W - 1 - int'(ctl.idx);
        trial_nxt = trial_q;
        for (int j = 0; j < RES_W; j++) begin
            if (j == b)          trial_nxt[j] = cmp;
            else if (j == b - 1) trial_nxt[j] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q  <= '0;
            result_q <= '0;
        end else begin
            if (ctl.load)        trial_q <= {1'b1, {(RES_W-1){1'b0}}};
            else if (ctl.step)   trial_q <= trial_nxt;
            if (ctl.finish)      result_q <= trial_q;
        end
    end

    assign trial  = trial_q;
    assign result = result_q;

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl.finish |=> $stable(result_q)); // R6
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $countones({ctl.load, ctl.step, ctl.finish}) <= 1); // R6

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = RES_BITS,
    parameter int CONV_CLKS = CONV_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       div_sel,
    input  logic [1:0]       acq_sel,
    input  logic             cont_en,
    input  logic             sw_start,
    input  logic             timer_ovf,
    input  logic             ext_cnv,
    input  logic             cmp_i,
    output logic [RES_W-1:0] dac_code_o,
    output logic             step_o,
    output logic             track_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);

    logic     tick;
    logic     idle;
    logic     accept;
    logic     pending;
    sar_ctl_t sar_ctl;

    adc_seq_clkdiv u_div (
        .clk  (clk),
        .rst  (rst),
        .idle (idle),
        .sel  (div_sel),
        .tick (tick)
    );

    adc_seq_trig u_trig (
        .clk       (clk),
        .rst       (rst),
        .sw_start  (sw_start),
        .timer_ovf (timer_ovf),
        .ext_cnv   (ext_cnv),
        .idle      (idle),
        .accept    (accept),
        .pending   (pending)
    );

    adc_seq_ctrl #(
        .RES_W     (RES_W),
        .CONV_CLKS (CONV_CLKS)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .pending (pending),
        .acq_sel (acq_sel),
        .cont_en (cont_en),
        .idle    (idle),
        .accept  (accept),
        .track   (track_o),
        .done    (done_o),
        .sar_ctl (sar_ctl)
    );

    adc_seq_sar #(
        .RES_W (RES_W)
    ) u_sar (
        .clk    (clk),
        .rst    (rst),
        .ctl    (sar_ctl),
        .cmp    (cmp_i),
        .trial  (dac_code_o),
        .result (result_o)
    );

    assign busy_o = !idle;
    assign step_o = sar_ctl.step;

endmodule

// File: tb/adc_seq_top_tb_top.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  div_sel, acq_sel;
    logic        cont_en, sw_start, timer_ovf, ext_cnv, cmp_i;
    logic [11:0] dac_code_o, result_o, vin;
    logic        step_o, track_o, busy_o, done_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    // Ideal comparator model
    assign cmp_i = (vin >= dac_code_o);

    adc_seq_top dut_i (
        .clk(clk), .rst(rst), .div_sel(div_sel), .acq_sel(acq_sel),
        .cont_en(cont_en), .sw_start(sw_start), .timer_ovf(timer_ovf),
        .ext_cnv(ext_cnv), .cmp_i(cmp_i), .dac_code_o(dac_code_o),
        .step_o(step_o), .track_o(track_o), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o)
    );

    function automatic int exp_ratio(int s);
        return 2 << s;
    endfunction

    function automatic int exp_frame(int d, int a);
        return (1 + (a + 1) + 15) * exp_ratio(d);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(int src);
        @(negedge clk);
        case (src)
            0: sw_start = 1'b1;
            1: timer_ovf = 1'b1;
            default: ext_cnv = 1'b1;
        endcase
        @(negedge clk);
        sw_start = 1'b0;
        timer_ovf = 1'b0;
        if (src == 2) begin
            @(negedge clk);
            ext_cnv = 1'b0;
        end
    endtask

    // act: 0 none, 1 fire every start source mid-conversion, 2 change ratio mid-conversion
    task automatic measure(int act, output int bcnt, output int tcnt, output int scnt,
                           output bit got, output bit busy_dn, output int res);
        bcnt = 0; tcnt = 0; scnt = 0; got = 0; busy_dn = 0; res = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            sw_start = 1'b0;
            timer_ovf = 1'b0;
            if (done_o) begin
                got = 1; busy_dn = busy_o; res = int'(result_o);
                break;
            end
            if (busy_o)  bcnt++;
            if (track_o) tcnt++;
            if (step_o)  scnt++;
            if (act == 1 && bcnt == 6 && busy_o) begin
                sw_start = 1'b1; timer_ovf = 1'b1; ext_cnv = 1'b1;
            end
            if (act == 2 && bcnt == 3 && busy_o) div_sel = 2'd3;
        end
    endtask

    task automatic run_one(int src, int d, int a, int v, int act);
        int bcnt, tcnt, scnt, res;
        bit got, bdn;
        @(negedge clk);
        div_sel = 2'(d); acq_sel = 2'(a); vin = 12'(v);
        repeat (3) @(negedge clk);
        pulse(src);
        measure(act, bcnt, tcnt, scnt, got, bdn, res);
        check(got, "R9 start accepted", int'(got), 1);
        check(bcnt == exp_frame(d, a), "R1 R2 R4 busy length", bcnt, exp_frame(d, a));
        check(tcnt == (a + 1) * exp_ratio(d), "R3 track length", tcnt, (a + 1) * exp_ratio(d));
        check(scnt == 12, "R6 step count", scnt, 12);
        check(!bdn, "R7 busy low at done", int'(bdn), 0);
        check(res == v, "R6 result", res, v);
        @(negedge clk);
        check(done_o == 1'b0, "R7 done width", int'(done_o), 0);
    endtask

    task automatic expect_idle(int cycles, string req);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (busy_o) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        int bcnt, tcnt, scnt, res;
        bit got, bdn;
        rst = 1'b1; div_sel = 2'd1; acq_sel = 2'd0; cont_en = 1'b0;
        sw_start = 1'b0; timer_ovf = 1'b0; ext_cnv = 1'b0; vin = 12'd0;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!busy_o && !track_o && !step_o && !done_o, "R10 controls low",
              int'({busy_o, track_o, step_o, done_o}), 0);
        check(result_o == 12'd0 && dac_code_o == 12'd0, "R10 codes zero",
              int'(result_o) + int'(dac_code_o), 0);

        // Directed corners: each ratio, each acquisition, extreme codes, each source
        run_one(0, 1, 0, 0, 0);
        run_one(1, 0, 3, 4095, 0);
        run_one(2, 2, 1, 2048, 0);
        run_one(0, 3, 2, 2047, 0);

        // R5 and R9: every source fires mid-conversion and ext is left high
        run_one(0, 1, 0, 1365, 1);
        expect_idle(3 * exp_frame(1, 0), "R5 R9 dropped requests");
        ext_cnv = 1'b0;
        repeat (4) @(negedge clk);
        run_one(2, 1, 1, 2730, 0);

        // R2: ratio change mid-conversion has no effect on that conversion
        run_one(0, 0, 1, 777, 2);

        // R8: continuous mode
        @(negedge clk);
        div_sel = 2'd1; acq_sel = 2'd2; vin = 12'd3001; cont_en = 1'b1;
        repeat (3) @(negedge clk);
        pulse(0);
        measure(0, bcnt, tcnt, scnt, got, bdn, res);
        check(got && bcnt == exp_frame(1, 2), "R8 first frame", bcnt, exp_frame(1, 2));
        check(bdn, "R8 busy held at done", int'(bdn), 1);
        check(res == 3001, "R8 first result", res, 3001);
        cont_en = 1'b0;
        measure(0, bcnt, tcnt, scnt, got, bdn, res);
        check(got && bcnt == exp_frame(1, 2) - 1, "R8 done spacing", bcnt, exp_frame(1, 2) - 1);
        check(res == 3001 && !bdn, "R8 second result", res, 3001);
        expect_idle(2 * exp_frame(1, 2), "R8 stops after clear");

        // Constrained random
        for (int k = 0; k < 24; k++) begin
            int d, a, v, s;
            d = int'($urandom % 4);
            a = int'($urandom % 4);
            v = int'($urandom % 4096);
            s = int'($urandom % 3);
            run_one(s, d, a, v, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule